// File: doc/BRIEF.md
# Four-Pin GPIO Expander on a Two-Wire Serial Target

This block is an I2C/SMBus target that gives a bus host four general-purpose pins. It runs on a fast system clock and oversamples SCL and SDA. Each line passes through a two-flop synchronizer and a stability filter. The block then finds START and STOP conditions, shifts in the address and data bytes, and acknowledges only its own fixed 7-bit address.

A write transfer carries a command byte first, which selects one of four byte-wide registers. Further bytes in the same transfer go to that register. A read transfer returns the selected register. The four registers are:

- the pin input levels (read-only), with optional per-pin inversion;
- the output latch;
- the inversion mask;
- the direction control.

Toward the pins the block drives a data bit and an output-enable for each pin. It samples the pin levels through a two-flop synchronizer.

Top module: `gpx_i2c_expander`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal the parameter DEV_ADDR. Bit 0 = 1 means read. On a mismatch it leaves SDA released and ignores every bit until the next START or STOP.
- R2: In a write transfer, the first byte after the address is the command. Command bits [2:0] select the register: 0 input, 1 output, 2 inversion, 3 direction. The same pointer is used by later data bytes and by later reads.
- R3: After reset, all pins are inputs (pin_oe = 0000) and pin_out = 1111. A read of the output register returns 0xFF, the direction register 0xFF, and the inversion register 0x00.
- R4: Reads of register 0 return the synchronized pin levels XOR the inversion mask in bits [3:0], whatever each pin's direction. A write to register 0 changes no register.
- R5: Bits [3:0] of the output register appear on pin_out. A read of register 1 returns the stored value, not the pin level.
- R6: A 1 in bit n of the inversion register inverts pin n in register-0 reads. A 0 leaves it unchanged.
- R7: pin_oe[n] is 1 exactly when bit n of the direction register is 0. A 1 in that bit makes pin n an input.
- R8: Written bits [7:4] are discarded. Reads return 1111 in bits [7:4] for registers 0, 1 and 3, and 0000 for register 2.
- R9: The pointer survives STOP. A read with no command byte returns the last selected register. Successive data bytes in one write all go to the same register, and successive read bytes return the same register.
- R10: For commands 4 to 7, data writes change no register and reads return 0x00.
- R11: A pulse on SCL or SDA shorter than FILT_CYC system clocks is ignored.
- R12: The block changes its SDA drive only while the filtered SCL is low. It releases SDA after a master NACK on a read byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, well above the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain drive) |
| pin_in | input | 4 | Pin input levels, asynchronous |
| pin_out | output | 4 | Per-pin output data |
| pin_oe | output | 4 | Per-pin output enable, 1 = driving |

## Verification
The bus assertions assume that the master follows the protocol. It moves SDA only while SCL is low, except to form START and STOP. It never attempts a START or STOP while the target holds SDA low. SCL low and high phases are also much longer than the filter plus synchronizer delay.

The bench master keeps within these limits. It changes SDA only at the middle of SCL low, and it uses a quarter-bit of twenty system clocks. It NACKs the last read byte before it issues STOP. The only deliberate exception is a two-clock spike on SCL, placed while SCL is low and SDA is steady, which exercises the filter.

// File: rtl/gpx_pkg.sv
// Shared types and sizes for the serial GPIO expander.
// Assumes byte-wide serial transfers and a 3-bit register pointer.
package gpx_pkg;
    localparam int BYTE_W = 8;
    localparam int PTR_W  = 3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RD_ACK,
        ST_IGNORE
    } bus_state_t;
endpackage

// File: rtl/gpx_line_filter.sv
// Synchronizes one serial line and passes a new level only after it has
// held for STABLE_CYC clocks. Assumes an idle-high line (reset value 1).
module gpx_line_filter #(
    parameter int STABLE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic line_o
);
    localparam int CW = $clog2(STABLE_CYC + 1);

    logic          s1_q, s2_q;
    logic [CW-1:0] run_q;

    // two-flop synchronizer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b1;
            s2_q <= 1'b1;
        end else begin
            s1_q <= raw_i;
            s2_q <= s1_q;
        end
    end

    // accept a new level once it has been steady long enough
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_o <= 1'b1;
            run_q  <= '0;
        end else if (s2_q == line_o) begin
            run_q <= '0;
        end else if (run_q == CW'(STABLE_CYC - 1)) begin
            line_o <= s2_q;
            run_q  <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    // R11
    filt_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(line_o) |-> ($past(s2_q) == line_o && $past(s2_q, 2) == line_o));
endmodule

// File: rtl/gpx_bus_engine.sv
// Serial target engine: START/STOP detection, address match, command
// pointer, write strobes and read shifting. Assumes filtered SCL/SDA
// and a bus clock far slower than clk.
module gpx_bus_engine
    import gpx_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h41
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl,
    input  logic              sda,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_data,
    output logic [PTR_W-1:0]  ptr,
    input  logic [BYTE_W-1:0] rd_data
);
    bus_state_t        state;
    logic [3:0]        bit_cnt;
    logic [BYTE_W-1:0] rx_sh, tx_sh;
    logic              rd_mode, nack_q, scl_q, sda_q;
    logic              scl_rise, scl_fall, start_det, stop_det, byte_end;

    assign scl_rise  = scl & ~scl_q;
    assign scl_fall  = ~scl & scl_q;
    assign start_det = scl & scl_q & sda_q & ~sda;
    assign stop_det  = scl & scl_q & ~sda_q & sda;
    assign byte_end  = scl_fall && (bit_cnt == 4'd8);

    // protocol sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            rd_mode <= 1'b0;
            nack_q  <= 1'b0;
            scl_q   <= 1'b1;
            sda_q   <= 1'b1;
            ptr     <= '0;
            wr_en   <= 1'b0;
            wr_data <= '0;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
            wr_en <= 1'b0;
            if (start_det) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
            end else if (stop_det) begin
                state <= ST_IDLE;
            end else begin
                case (state)
                    ST_ADDR, ST_CMD, ST_WDATA: begin
                        if (scl_rise) begin
                            rx_sh   <= {rx_sh[BYTE_W-2:0], sda};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (byte_end) begin
                            if (state == ST_ADDR) begin
                                if (rx_sh[7:1] == DEV_ADDR) begin
                                    rd_mode <= rx_sh[0];
                                    tx_sh   <= rd_data;
                                    state   <= ST_ADDR_ACK;
                                end else begin
                                    state <= ST_IGNORE;
                                end
                            end else if (state == ST_CMD) begin
                                ptr   <= rx_sh[PTR_W-1:0];
                                state <= ST_CMD_ACK;
                            end else begin
                                wr_en   <= 1'b1;
                                wr_data <= rx_sh;
                                state   <= ST_WDATA_ACK;
                            end
                        end
                    end
                    ST_ADDR_ACK: if (scl_fall) begin
                        bit_cnt <= '0;
                        state   <= rd_mode ? ST_RDATA : ST_CMD;
                    end
                    ST_CMD_ACK, ST_WDATA_ACK: if (scl_fall) begin
                        bit_cnt <= '0;
                        state   <= ST_WDATA;
                    end
                    ST_RDATA: begin
                        if (scl_rise) bit_cnt <= bit_cnt + 1'b1;
                        else if (byte_end) state <= ST_RD_ACK;
                        else if (scl_fall) tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) nack_q <= sda;
                        else if (scl_fall) begin
                            if (nack_q) state <= ST_IGNORE;
                            else begin
                                tx_sh   <= rd_data;
                                bit_cnt <= '0;
                                state   <= ST_RDATA;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // open-drain drive: acknowledge slots and read data bits
    always_comb begin
        case (state)
            ST_ADDR_ACK, ST_CMD_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_RDATA:                              sda_oe = ~tx_sh[BYTE_W-1];
            default:                               sda_oe = 1'b0;
        endcase
    end

    // R12
    sda_move_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl);

    // R1
    addr_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && byte_end && !start_det && !stop_det && rx_sh[7:1] != DEV_ADDR) |=> !sda_oe);

    // R12
    nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_ACK && scl_fall && nack_q && !start_det && !stop_det) |=> !sda_oe);
endmodule

// File: rtl/gpx_port_regs.sv
// Pin-side register set: output latch, inversion mask, direction control
// and synchronized pin sampling. Assumes one write strobe per data byte.
module gpx_port_regs
    import gpx_pkg::*;
#(
    parameter int NPIN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  ptr,
    output logic [BYTE_W-1:0] rd_data,
    input  logic [NPIN-1:0]   pin_in,
    output logic [NPIN-1:0]   pin_out,
    output logic [NPIN-1:0]   pin_oe
);
    localparam int PAD = BYTE_W - NPIN;

    logic [NPIN-1:0] out_q, inv_q, dir_q, pin_s1, pin_s2;
    logic            unused_hi;

    assign unused_hi = ^wr_data[BYTE_W-1:NPIN];

    // pin input synchronizer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_s1 <= '1;
            pin_s2 <= '1;
        end else begin
            pin_s1 <= pin_in;
            pin_s2 <= pin_s1;
        end
    end

    // register writes selected by the pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '1;
            inv_q <= '0;
            dir_q <= '1;
        end else if (wr_en) begin
            case (ptr)
                3'd1:    out_q <= wr_data[NPIN-1:0];
                3'd2:    inv_q <= wr_data[NPIN-1:0];
                3'd3:    dir_q <= wr_data[NPIN-1:0];
                default: ;
            endcase
        end
    end

    // read multiplexer with fixed upper bits
    always_comb begin
        case (ptr)
            3'd0:    rd_data = {{PAD{1'b1}}, pin_s2 ^ inv_q};
            3'd1:    rd_data = {{PAD{1'b1}}, out_q};
            3'd2:    rd_data = {{PAD{1'b0}}, inv_q};
            3'd3:    rd_data = {{PAD{1'b1}}, dir_q};
            default: rd_data = '0;
        endcase
    end

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        assign pin_oe[i]  = ~dir_q[i];
        assign pin_out[i] = out_q[i];
    end

    // R4
    ro_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ptr == 3'd0) |=> ($stable(pin_out) && $stable(pin_oe) && $stable(inv_q)));

    // R10
    bad_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ptr[2]) |=> ($stable(pin_out) && $stable(pin_oe) && $stable(inv_q)));
endmodule

// File: rtl/gpx_i2c_expander.sv
// Top of the serial GPIO expander: two line filters, the bus engine and
// the pin register set. Assumes clk is many times faster than SCL.
module gpx_i2c_expander
    import gpx_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h41,
    parameter int         NPIN     = 4,
    parameter int         FILT_CYC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_i,
    input  logic            sda_i,
    output logic            sda_oe_o,
    input  logic [NPIN-1:0] pin_in,
    output logic [NPIN-1:0] pin_out,
    output logic [NPIN-1:0] pin_oe
);
    logic              scl_f, sda_f, wr_en;
    logic [BYTE_W-1:0] wr_data, rd_data;
    logic [PTR_W-1:0]  ptr;

    gpx_line_filter #(.STABLE_CYC(FILT_CYC)) u_scl_filt (
        .clk(clk), .rst_n(rst_n), .raw_i(scl_i), .line_o(scl_f));

    gpx_line_filter #(.STABLE_CYC(FILT_CYC)) u_sda_filt (
        .clk(clk), .rst_n(rst_n), .raw_i(sda_i), .line_o(sda_f));

    gpx_bus_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
        .clk(clk), .rst_n(rst_n), .scl(scl_f), .sda(sda_f), .sda_oe(sda_oe_o),
        .wr_en(wr_en), .wr_data(wr_data), .ptr(ptr), .rd_data(rd_data));

    gpx_port_regs #(.NPIN(NPIN)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .ptr(ptr),
        .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe));
endmodule

// File: tb/sim_gpx_i2c_expander.sv
module sim_gpx_i2c_expander;
    localparam int         CLK_PERIOD = 10;
    localparam int         QTR        = 20;
    localparam logic [6:0] ADDR       = 7'h41;
    localparam int         WDOG_LIM   = 180000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1, sda_m = 1'b1, glitch = 1'b0;
    logic [3:0] pin_in = 4'b0101;
    logic       sda_oe;
    logic [3:0] pin_out, pin_oe;
    logic       sda_bus, scl_bus;
    int         n_chk = 0, n_bad = 0, cyc = 0;

    assign sda_bus = sda_m & ~sda_oe;
    assign scl_bus = scl_m | glitch;

    always #(CLK_PERIOD / 2) clk = ~clk;

    gpx_i2c_expander #(.DEV_ADDR(ADDR)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
        .sda_oe_o(sda_oe), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe));

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_q(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q(QTR);
        scl_m = 1'b1; wait_q(QTR);
        sda_m = 1'b0; wait_q(QTR);
        scl_m = 1'b0; wait_q(QTR);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q(QTR);
        scl_m = 1'b1; wait_q(QTR);
        sda_m = 1'b1; wait_q(QTR);
    endtask

    task automatic bus_bit(input logic b, input logic spike, output logic got);
        sda_m = b;
        if (spike) begin
            wait_q(QTR / 2);
            glitch = 1'b1; wait_q(2);
            glitch = 1'b0; wait_q(QTR / 2 - 2);
        end else begin
            wait_q(QTR);
        end
        scl_m = 1'b1; wait_q(QTR);
        got = sda_bus; wait_q(QTR);
        scl_m = 1'b0; wait_q(QTR);
    endtask

    task automatic put_byte(input logic [7:0] d, input logic spike, output logic ack_n);
        logic g;
        for (int i = 7; i >= 0; i--) bus_bit(d[i], spike && (i == 3), g);
        bus_bit(1'b1, 1'b0, ack_n);
    endtask

    task automatic get_byte(input logic nack, output logic [7:0] d);
        logic g;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, 1'b0, g);
            d[i] = g;
        end
        bus_bit(nack, 1'b0, g);
    endtask

    task automatic reg_write(input logic [7:0] cmd, input logic [7:0] d);
        logic a;
        bus_start();
        put_byte({ADDR, 1'b0}, 1'b0, a);
        put_byte(cmd, 1'b0, a);
        put_byte(d, 1'b0, a);
        bus_stop();
    endtask

    task automatic reg_read(input logic [7:0] cmd, output logic [7:0] d);
        logic a;
        bus_start();
        put_byte({ADDR, 1'b0}, 1'b0, a);
        put_byte(cmd, 1'b0, a);
        bus_start();
        put_byte({ADDR, 1'b1}, 1'b0, a);
        get_byte(1'b1, d);
        bus_stop();
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R3 pin_oe", {4'h0, pin_oe}, 8'h00);
        check("R3 pin_out", {4'h0, pin_out}, 8'h0F);
        reg_read(8'd3, d); check("R3 dir read", d, 8'hFF);
        reg_read(8'd1, d); check("R3 out read", d, 8'hFF);
        reg_read(8'd2, d); check("R3 inv read", d, 8'h00);
        reg_read(8'd0, d); check("R4 input read", d, 8'hF5);
    endtask

    task automatic t_addr();
        logic a;
        bus_start();
        put_byte({7'h22, 1'b0}, 1'b0, a);
        check("R1 foreign address NACK", {7'h0, a}, 8'h01);
        put_byte(8'd3, 1'b0, a);
        put_byte(8'h00, 1'b0, a);
        bus_stop();
        check("R1 foreign transfer ignored", {4'h0, pin_oe}, 8'h00);
        bus_start();
        put_byte({ADDR, 1'b0}, 1'b0, a);
        check("R1 own address ACK", {7'h0, a}, 8'h00);
        bus_stop();
    endtask

    task automatic t_drive();
        logic [7:0] d;
        reg_write(8'd3, 8'hF0);
        check("R7 all outputs", {4'h0, pin_oe}, 8'h0F);
        reg_write(8'd1, 8'hA5);
        check("R5 pin_out", {4'h0, pin_out}, 8'h05);
        reg_read(8'd1, d); check("R8 out upper ones", d, 8'hF5);
        reg_read(8'd3, d); check("R8 dir upper ones", d, 8'hF0);
        reg_write(8'd3, 8'h0C);
        check("R7 mixed direction", {4'h0, pin_oe}, 8'h03);
        pin_in = 4'b1010;
        reg_read(8'd1, d); check("R5 latched not pin", d, 8'hF5);
        reg_read(8'd0, d); check("R4 all pins any direction", d, 8'hFA);
    endtask

    task automatic t_invert();
        logic [7:0] d;
        reg_write(8'd2, 8'hF6);
        reg_read(8'd2, d); check("R8 inv upper zeros", d, 8'h06);
        reg_read(8'd0, d); check("R6 inverted input", d, 8'hFC);
    endtask

    task automatic t_input_ro();
        logic [7:0] d;
        reg_write(8'd0, 8'h00);
        check("R4 write ignored out", {4'h0, pin_out}, 8'h05);
        check("R4 write ignored dir", {4'h0, pin_oe}, 8'h03);
        reg_read(8'd2, d); check("R4 write ignored inv", d, 8'h06);
    endtask

    task automatic t_pointer();
        logic       a;
        logic [7:0] d;
        pin_in = 4'b0000;
        bus_start();
        put_byte({ADDR, 1'b0}, 1'b0, a);
        put_byte(8'd3, 1'b0, a);
        bus_stop();
        bus_start();
        put_byte({ADDR, 1'b1}, 1'b0, a);
        get_byte(1'b0, d); check("R9 read keeps pointer", d, 8'hFC);
        get_byte(1'b1, d); check("R9 repeat read same reg", d, 8'hFC);
        wait_q(QTR);
        check("R12 SDA released after NACK", {7'h0, sda_bus}, 8'h01);
        bus_stop();
        reg_read(8'd0, d); check("R2 command selects input", d, 8'hF6);
        bus_start();
        put_byte({ADDR, 1'b0}, 1'b0, a);
        put_byte(8'd1, 1'b0, a);
        put_byte(8'h03, 1'b0, a);
        put_byte(8'h0A, 1'b0, a);
        bus_stop();
        check("R9 no auto-increment out", {4'h0, pin_out}, 8'h0A);
        check("R9 no auto-increment dir", {4'h0, pin_oe}, 8'h03);
    endtask

    task automatic t_bad_cmd();
        logic [7:0] d;
        reg_write(8'd5, 8'h00);
        check("R10 write out unchanged", {4'h0, pin_out}, 8'h0A);
        check("R10 write dir unchanged", {4'h0, pin_oe}, 8'h03);
        reg_read(8'd5, d); check("R10 read zero", d, 8'h00);
    endtask

    task automatic t_glitch();
        logic a;
        bus_start();
        put_byte({ADDR, 1'b0}, 1'b0, a);
        put_byte(8'd1, 1'b0, a);
        put_byte(8'h06, 1'b1, a);
        bus_stop();
        check("R11 spike on SCL ignored", {4'h0, pin_out}, 8'h06);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WDOG_LIM) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        wait_q(5);
        rst_n = 1'b1;
        wait_q(10);
        t_reset();
        t_addr();
        t_drive();
        t_invert();
        t_input_ro();
        t_pointer();
        t_bad_cmd();
        t_glitch();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule